// File: doc/BRIEF.md
# Byte-Phase I2C Master with Two-Register Host Interface

This block is an I2C controller that a processor operates through two byte-wide registers. Register 0 holds data and register 1 holds control. Each launch performs one byte phase. Command bits choose what the phase contains: an optional start condition first, then either eight bits shifted out or eight bits shifted in, the ninth (acknowledge) clock, and an optional stop condition at the end. Software builds a full transaction from a series of phases. A typical series is start plus device address, then a register index, then the data. A read begins again with a repeated start. The block has no multi-phase sequencing of its own.

The bus lines are open-drain. `scl_pull` and `sda_pull` high mean the block pulls the line low, and `scl_i` and `sda_i` carry the resolved line levels back in. Timing is set in quarter bit periods, and each quarter lasts `quarter_div + 1` clock cycles. Start and stop conditions hold the lines for two quarters (half a bit period) on either side of the defining SDA edge. When the target holds SCL low, the block waits before it counts the high time.

Top module: `i2c_byte_master`

## Requirements
- R1: Address 0 (`bus_sel`=0) is the data register and address 1 is the control register. The control register reads as {busy[7], keep[6], 0, nack[4], 0, stop[2], start[1], dir[0]}. While the block is idle, a write to address 0 stores the byte, and it reads back on `data_rd`.
- R2: A control write with bit 7 set while idle launches a phase. Bit 7 then reads 1 until the phase ends, and the hardware clears it. A control write with bit 7 clear stores bits 6, 2, 1 and 0 and launches nothing.
- R3: One quarter lasts `quarter_div+1` cycles. Each data bit takes four quarters: SCL is pulled low for two quarters and released for two. Bits go out MSB first, and the ninth clock is the acknowledge clock.
- R4: With bit 1 set, the phase opens with a start condition. SDA is released while SCL is pulled low for one quarter. SCL is then released for two quarters, SDA is pulled low, and SCL stays released for two more quarters.
- R5: With bit 2 set, the phase ends with a stop condition. SDA is pulled low while SCL is low. SCL is then released for two quarters before SDA is released, and after that both lines stay released. Without bit 2, SCL stays pulled low and SDA stays released between phases.
- R6: With bit 0 clear, the data register byte is sent and SDA is released on the ninth clock. Control bit 4 is set if SDA reads high at the sample point of that clock. The bit is cleared when the next phase is launched.
- R7: With bit 0 set, SDA is sampled at the end of the first released-SCL quarter of each bit. The 8 bits are assembled MSB first and written to the data register when the phase ends. On the ninth clock the block pulls SDA low (acknowledge) if bit 2 is clear and releases SDA if bit 2 is set.
- R8: Apart from start and stop conditions, SDA changes only in quarters where SCL is pulled low. The ninth clock is followed by one extra quarter with SCL low and SDA unchanged.
- R9: In a released-SCL quarter that waits on the line, no cycle counts toward the quarter while `scl_i` is low.
- R10: Writes to either register while busy have no effect.
- R11: After reset both lines are released, busy is clear and both registers read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_wr | input | 1 | Register write strobe |
| bus_sel | input | 1 | Register select: 0 data, 1 control |
| bus_wdata | input | 8 | Write data |
| data_rd | output | 8 | Data register contents |
| ctrl_rd | output | 8 | Control and status readback |
| quarter_div | input | DIV_W | Quarter-period length minus one, in clocks |
| scl_i | input | 1 | Resolved SCL level |
| sda_i | input | 1 | Resolved SDA level |
| scl_pull | output | 1 | Pull SCL low when 1 |
| sda_pull | output | 1 | Pull SDA low when 1 |

## Verification
The bench exercises the following cases:
- A repeated start issued from the parked state (SCL held low). A wrong preamble would drop SDA while SCL is low, and no start would be seen on the bus.
- A transmit with a missing acknowledge, followed by one with an acknowledge. A design that never clears the status bit would fail the second phase.
- A read both with and without stop. A reversed acknowledge drive would show on the ninth clock.
- A stretched SCL-high quarter. A design that counts regardless of the line would end the quarter early.
- Writes placed in the middle of a busy phase. Accepting them would clear busy or corrupt the byte.

// File: rtl/i2c_bm_pkg.sv
package i2c_bm_pkg;
  typedef enum logic [1:0] {PH_IDLE, PH_START, PH_BITS, PH_STOP} phase_e;

  localparam int CB_DIR   = 0;
  localparam int CB_START = 1;
  localparam int CB_STOP  = 2;
  localparam int CB_NACK  = 4;
  localparam int CB_KEEP  = 6;
  localparam int CB_BUSY  = 7;

  localparam int BYTE_W = 8;
endpackage

// File: rtl/i2c_bm_qtimer.sv
module i2c_bm_qtimer #(
  parameter int DIV_W = 12
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic             en,
  input  logic [DIV_W-1:0] div,
  output logic             tick
);
  logic [DIV_W-1:0] cnt_q, cnt_d;
  logic             cnt_en;

  assign tick   = en && (cnt_q == div);
  assign cnt_en = clr || en;

  always_comb begin
    cnt_d = cnt_q;
    if (clr || tick) cnt_d = '0;
    else if (en)     cnt_d = cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end
endmodule

// File: rtl/i2c_bm_engine.sv
module i2c_bm_engine
  import i2c_bm_pkg::*;
#(
  parameter int DIV_W = 12
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              go,
  input  logic              go_dir,
  input  logic              go_start,
  input  logic              go_stop,
  input  logic [BYTE_W-1:0] go_byte,
  input  logic [DIV_W-1:0]  div,
  input  logic              scl_i,
  input  logic              sda_i,
  output logic              scl_pull,
  output logic              sda_pull,
  output logic              done,
  output logic [BYTE_W-1:0] rx_byte,
  output logic              nack
);
  localparam logic [3:0] ACK_BIT = 4'(BYTE_W);

  phase_e            phase_q, phase_d;
  logic [2:0]        step_q, step_d;
  logic [3:0]        bitn_q, bitn_d;
  logic [BYTE_W-1:0] sh_q, sh_d;
  logic              samp_q, samp_d, nack_q, nack_d;
  logic              rd_q, rd_d, sp_q, sp_d, park_q, park_d;
  logic [1:0]        pulls_q, pulls_d;
  logic              go_ok, tick, wait_line, st_en;

  function automatic logic [1:0] line_pulls(phase_e ph, logic [2:0] st, logic [3:0] bn,
                                            logic b7, logic rd, logic sp, logic park,
                                            logic sda_prev);
    logic scl, sda;
    scl = 1'b0;
    sda = 1'b0;
    case (ph)
      PH_IDLE:  scl = park;
      PH_START: begin
        scl = (st == 3'd0);
        sda = (st >= 3'd3);
      end
      PH_BITS: begin
        scl = (st < 3'd2) || (st == 3'd4);
        if (st == 3'd0 || st == 3'd4) sda = sda_prev;
        else if (bn < ACK_BIT)        sda = !rd && !b7;
        else                          sda = rd && !sp;
      end
      PH_STOP: begin
        scl = (st == 3'd0);
        sda = (st < 3'd3);
      end
      default: ;
    endcase
    return {scl, sda};
  endfunction

  assign go_ok     = go && (phase_q == PH_IDLE);
  assign wait_line = ((phase_q == PH_START) && (step_q == 3'd1)) ||
                     ((phase_q == PH_BITS)  && (step_q == 3'd2)) ||
                     ((phase_q == PH_STOP)  && (step_q == 3'd1));
  assign st_en     = go_ok || tick;

  i2c_bm_qtimer #(.DIV_W(DIV_W)) u_qtimer (
    .clk   (clk),
    .rst_n (rst_n),
    .clr   (go_ok),
    .en    ((phase_q != PH_IDLE) && (!wait_line || scl_i)),
    .div   (div),
    .tick  (tick)
  );

  always_comb begin
    phase_d = phase_q;
    step_d  = step_q;
    bitn_d  = bitn_q;
    sh_d    = sh_q;
    samp_d  = samp_q;
    nack_d  = nack_q;
    rd_d    = rd_q;
    sp_d    = sp_q;
    park_d  = park_q;
    done    = 1'b0;
    if (go_ok) begin
      phase_d = go_start ? PH_START : PH_BITS;
      step_d  = 3'd0;
      bitn_d  = 4'd0;
      sh_d    = go_dir ? '1 : go_byte;
      nack_d  = 1'b0;
      rd_d    = go_dir;
      sp_d    = go_stop;
    end else if (tick) begin
      step_d = step_q + 3'd1;
      case (phase_q)
        PH_START: if (step_q == 3'd4) begin
          phase_d = PH_BITS;
          step_d  = 3'd0;
        end
        PH_BITS: begin
          if (step_q == 3'd2) begin
            samp_d = sda_i;
            if (bitn_q == ACK_BIT && !rd_q) nack_d = sda_i;
          end
          if (step_q == 3'd3 && bitn_q != ACK_BIT) begin
            sh_d   = {sh_q[BYTE_W-2:0], samp_q};
            bitn_d = bitn_q + 4'd1;
            step_d = 3'd0;
          end
          if (step_q == 3'd4) begin
            step_d = 3'd0;
            if (sp_q) phase_d = PH_STOP;
            else begin
              phase_d = PH_IDLE;
              park_d  = 1'b1;
              done    = 1'b1;
            end
          end
        end
        PH_STOP: if (step_q == 3'd3) begin
          phase_d = PH_IDLE;
          step_d  = 3'd0;
          park_d  = 1'b0;
          done    = 1'b1;
        end
        default: ;
      endcase
    end
    pulls_d = line_pulls(phase_d, step_d, bitn_d, sh_d[BYTE_W-1], rd_d, sp_d, park_d, pulls_q[0]);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_q <= PH_IDLE;
      step_q  <= '0;
      bitn_q  <= '0;
      sh_q    <= '0;
      samp_q  <= 1'b0;
      nack_q  <= 1'b0;
      rd_q    <= 1'b0;
      sp_q    <= 1'b0;
      park_q  <= 1'b0;
      pulls_q <= '0;
    end else if (st_en) begin
      phase_q <= phase_d;
      step_q  <= step_d;
      bitn_q  <= bitn_d;
      sh_q    <= sh_d;
      samp_q  <= samp_d;
      nack_q  <= nack_d;
      rd_q    <= rd_d;
      sp_q    <= sp_d;
      park_q  <= park_d;
      pulls_q <= pulls_d;
    end
  end

  assign scl_pull = pulls_q[1];
  assign sda_pull = pulls_q[0];
  assign rx_byte  = sh_q;
  assign nack     = nack_q;
endmodule

// File: rtl/i2c_byte_master.sv
module i2c_byte_master
  import i2c_bm_pkg::*;
#(
  parameter int DIV_W = 12
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             bus_wr,
  input  logic             bus_sel,
  input  logic [7:0]       bus_wdata,
  output logic [7:0]       data_rd,
  output logic [7:0]       ctrl_rd,
  input  logic [DIV_W-1:0] quarter_div,
  input  logic             scl_i,
  input  logic             sda_i,
  output logic             scl_pull,
  output logic             sda_pull
);
  logic [1:0]        rs_q;
  logic              core_rst_n;
  logic [BYTE_W-1:0] data_q, data_d, rx_byte;
  logic              busy_q, busy_d, keep_q, keep_d;
  logic              stop_q, stop_d, start_q, start_d, dir_q, dir_d;
  logic              wr_data, wr_ctrl, go, done, nack, upd;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rs_q <= '0;
    else        rs_q <= {rs_q[0], 1'b1};
  end
  assign core_rst_n = rs_q[1];

  assign wr_data = bus_wr && !bus_sel && !busy_q;
  assign wr_ctrl = bus_wr &&  bus_sel && !busy_q;
  assign go      = wr_ctrl && bus_wdata[CB_BUSY];
  assign upd     = wr_data || wr_ctrl || done;

  always_comb begin
    data_d  = data_q;
    busy_d  = busy_q;
    keep_d  = keep_q;
    stop_d  = stop_q;
    start_d = start_q;
    dir_d   = dir_q;
    if (wr_data) data_d = bus_wdata;
    if (wr_ctrl) begin
      busy_d  = bus_wdata[CB_BUSY];
      keep_d  = bus_wdata[CB_KEEP];
      stop_d  = bus_wdata[CB_STOP];
      start_d = bus_wdata[CB_START];
      dir_d   = bus_wdata[CB_DIR];
    end
    if (done) begin
      busy_d = 1'b0;
      if (dir_q) data_d = rx_byte;
    end
  end

  always_ff @(posedge clk or negedge core_rst_n) begin
    if (!core_rst_n) begin
      data_q  <= '0;
      busy_q  <= 1'b0;
      keep_q  <= 1'b0;
      stop_q  <= 1'b0;
      start_q <= 1'b0;
      dir_q   <= 1'b0;
    end else if (upd) begin
      data_q  <= data_d;
      busy_q  <= busy_d;
      keep_q  <= keep_d;
      stop_q  <= stop_d;
      start_q <= start_d;
      dir_q   <= dir_d;
    end
  end

  i2c_bm_engine #(.DIV_W(DIV_W)) u_engine (
    .clk      (clk),
    .rst_n    (core_rst_n),
    .go       (go),
    .go_dir   (bus_wdata[CB_DIR]),
    .go_start (bus_wdata[CB_START]),
    .go_stop  (bus_wdata[CB_STOP]),
    .go_byte  (data_q),
    .div      (quarter_div),
    .scl_i    (scl_i),
    .sda_i    (sda_i),
    .scl_pull (scl_pull),
    .sda_pull (sda_pull),
    .done     (done),
    .rx_byte  (rx_byte),
    .nack     (nack)
  );

  assign data_rd = data_q;
  assign ctrl_rd = {busy_q, keep_q, 1'b0, nack, 1'b0, stop_q, start_q, dir_q};
endmodule

// File: rtl/i2c_bm_checker.sv
module i2c_bm_checker (
  input logic       clk,
  input logic       rst_n,
  input logic       bus_wr,
  input logic       bus_sel,
  input logic [7:0] bus_wdata,
  input logic [7:0] data_rd,
  input logic [7:0] ctrl_rd,
  input logic       scl_pull,
  input logic       sda_pull
);
  AST_BUSY_NEEDS_LAUNCH: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ctrl_rd[7]) |-> $past(bus_wr && bus_sel && bus_wdata[7])); // R2

  AST_DATA_LOCKED_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    (ctrl_rd[7] && bus_wr && !bus_sel) |=> ($stable(data_rd) || !ctrl_rd[7])); // R10

  AST_CTRL_LOCKED_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    (ctrl_rd[7] && bus_wr && bus_sel) |=> $stable(ctrl_rd[2:0])); // R10

  AST_START_ONLY_ASKED: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(sda_pull) && !scl_pull && $past(!scl_pull)) |-> (ctrl_rd[1] && ctrl_rd[7])); // R4

  AST_STOP_ONLY_ASKED: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(sda_pull) && !scl_pull && $past(!scl_pull)) |-> (ctrl_rd[2] && ctrl_rd[7])); // R5

  AST_IDLE_SDA_FREE: assert property (@(posedge clk) disable iff (!rst_n)
    !ctrl_rd[7] |-> !sda_pull); // R5

  AST_STOP_FREES_SCL: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(ctrl_rd[7]) && ctrl_rd[2]) |-> !scl_pull); // R5
endmodule

bind i2c_byte_master i2c_bm_checker u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .bus_wr    (bus_wr),
  .bus_sel   (bus_sel),
  .bus_wdata (bus_wdata),
  .data_rd   (data_rd),
  .ctrl_rd   (ctrl_rd),
  .scl_pull  (scl_pull),
  .sda_pull  (sda_pull)
);

// File: tb/i2c_byte_master_tb.sv
module i2c_byte_master_tb;
  localparam int CLK_PERIOD = 10;
  localparam int DIV_W = 12;

  logic             clk, rst_n, bus_wr, bus_sel;
  logic [7:0]       bus_wdata, data_rd, ctrl_rd;
  logic [DIV_W-1:0] quarter_div;
  logic             scl_pull, sda_pull, stretch, tgt_low;
  logic             scl_line, sda_line;

  int n_chk = 0, n_fail = 0, stretch_left = 0, poke_at = -1, cyc = 0;
  bit exp_sda = 0, exp_park = 0;

  assign scl_line = !scl_pull && !stretch;
  assign sda_line = !sda_pull && !tgt_low;

  i2c_byte_master #(.DIV_W(DIV_W)) u_dut (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_sel(bus_sel), .bus_wdata(bus_wdata),
    .data_rd(data_rd), .ctrl_rd(ctrl_rd), .quarter_div(quarter_div),
    .scl_i(scl_line), .sda_i(sda_line), .scl_pull(scl_pull), .sda_pull(sda_pull)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = !clk;

  task automatic check(input bit ok, input string req, input string what, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
    end
  endtask

  // One quarter of expected line state; R3 quarter length, R9 waiting on a held SCL
  task automatic do_step(input bit e_scl, input bit e_sda, input bit w);
    int n = 0;
    while (n < int'(quarter_div) + 1) begin
      @(negedge clk);
      if (w && stretch_left > 0) begin stretch = 1'b1; stretch_left--; end
      else stretch = 1'b0;
      check({scl_pull, sda_pull, ctrl_rd[7]} == {e_scl, e_sda, 1'b1}, "R3/R8/R9", "scl,sda,busy",
            int'({scl_pull, sda_pull, ctrl_rd[7]}), int'({e_scl, e_sda, 1'b1}));
      if (poke_at >= 0 && cyc == poke_at) begin bus_wr = 1; bus_sel = 1; bus_wdata = 8'h00; end
      else if (poke_at >= 0 && cyc == poke_at + 1) begin bus_sel = 0; bus_wdata = 8'h3C; end
      else if (poke_at >= 0 && cyc == poke_at + 2) bus_wr = 0;
      cyc++;
      if (!w || !stretch) n++;
    end
    exp_sda = e_sda;
  endtask

  task automatic run_phase(input logic [7:0] cmd, input logic [7:0] tx, input logic [7:0] rx,
                           input bit ack, input string req);
    bit rd, st, sp, v;
    logic [7:0] exp_data;
    rd = cmd[0]; st = cmd[1]; sp = cmd[2];
    @(negedge clk);
    if (!rd) begin
      bus_wr = 1; bus_sel = 0; bus_wdata = tx;
      @(negedge clk);
    end
    bus_wr = 1; bus_sel = 1; bus_wdata = cmd;
    @(posedge clk); #1 bus_wr = 0;
    cyc = 0;
    if (st) begin // R4
      do_step(1, 0, 0); do_step(0, 0, 1); do_step(0, 0, 0); do_step(0, 1, 0); do_step(0, 1, 0);
    end
    for (int b = 0; b < 9; b++) begin
      v = (b < 8) ? (!rd && !tx[7-b]) : (rd && !sp);
      do_step(1, exp_sda, 0);
      if (rd && b < 8)      tgt_low = !rx[7-b];
      else if (!rd && b == 8) tgt_low = ack;
      else                  tgt_low = 1'b0;
      do_step(1, v, 0); do_step(0, v, 1); do_step(0, v, 0);
      if (b == 8) do_step(1, exp_sda, 0);
    end
    tgt_low = 1'b0;
    if (sp) begin // R5
      do_step(1, 1, 0); do_step(0, 1, 1); do_step(0, 1, 0); do_step(0, 0, 0);
    end
    exp_park = !sp;
    exp_sda = 0;
    poke_at = -1;
    @(negedge clk);
    check(ctrl_rd[7] == 1'b0, "R2", {req, " busy cleared"}, int'(ctrl_rd[7]), 0);
    check({scl_pull, sda_pull} == {exp_park, 1'b0}, "R5", {req, " lines after phase"},
          int'({scl_pull, sda_pull}), int'({exp_park, 1'b0}));
    exp_data = rd ? rx : tx;
    check(data_rd == exp_data, rd ? "R7" : "R10", {req, " data reg"}, int'(data_rd), int'(exp_data));
    check(ctrl_rd == {1'b0, cmd[6], 1'b0, (!rd && !ack), 1'b0, cmd[2:0]}, "R6", {req, " ctrl readback"},
          int'(ctrl_rd), int'({1'b0, cmd[6], 1'b0, (!rd && !ack), 1'b0, cmd[2:0]}));
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    rst_n = 0; bus_wr = 0; bus_sel = 0; bus_wdata = 0; quarter_div = 1;
    stretch = 0; tgt_low = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    repeat (4) @(negedge clk);
    // R11 reset state
    check({scl_pull, sda_pull} == 2'b00, "R11", "lines after reset", int'({scl_pull, sda_pull}), 0);
    check(ctrl_rd == 8'h00, "R11", "ctrl after reset", int'(ctrl_rd), 0);
    check(data_rd == 8'h00, "R11", "data after reset", int'(data_rd), 0);
    // R1 data register write while idle
    bus_wr = 1; bus_sel = 0; bus_wdata = 8'hA5;
    @(negedge clk); bus_wr = 0;
    check(data_rd == 8'hA5, "R1", "data write idle", int'(data_rd), 8'hA5);
    // R4 start + address, acknowledged
    run_phase(8'hC2, 8'h7A, 8'h00, 1, "R4 start addr");
    // R6 not acknowledged; R10 writes during busy ignored
    poke_at = 20;
    run_phase(8'hC0, 8'h31, 8'h00, 0, "R6 nack R10 poke");
    // R6 status cleared by the next launch
    run_phase(8'hC0, 8'h00, 8'h00, 1, "R6 ack clears");
    // R4 repeated start from parked SCL
    run_phase(8'hC2, 8'h7B, 8'h00, 1, "R4 restart");
    // R7 read with acknowledge, no stop
    run_phase(8'hC1, 8'h00, 8'h96, 0, "R7 read ack");
    // R7 read ending with stop; R9 stretched SCL on first waiting quarter
    stretch_left = 5;
    run_phase(8'hC5, 8'h00, 8'h3C, 0, "R7 read stop R9");
    // R3 longer quarter; start and stop in one phase
    quarter_div = 3;
    run_phase(8'hC6, 8'h80, 8'h00, 1, "R3 div3 start stop");
    // R2 control write with bit 7 clear launches nothing
    @(negedge clk);
    bus_wr = 1; bus_sel = 1; bus_wdata = 8'h46;
    @(negedge clk); bus_wr = 0;
    for (int i = 0; i < 6; i++) begin
      @(negedge clk);
      check(ctrl_rd[7] == 1'b0 && {scl_pull, sda_pull} == 2'b00, "R2", "no launch",
            int'({ctrl_rd[7], scl_pull, sda_pull}), 0);
    end
    check(ctrl_rd == 8'h46, "R2", "stored ctrl bits", int'(ctrl_rd), 8'h46);
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule